// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block is one DMA channel. Software fills four registers: a source pointer, a destination pointer, a 24-bit unit count and a control word. Once it is enabled, the channel answers a request input by moving data one unit at a time. Each unit is one read at the source pointer followed by one write of the same data at the destination pointer, carried on a simple request/acknowledge memory port. After each unit, each pointer stays put, moves up or moves down by the unit size, and the count drops by one.

The control word selects the unit size (1, 2, 4 or 16 bytes), a mode for each pointer, and the pacing. In cycle-steal pacing, each sampled request moves exactly one unit and then frees the port. In burst pacing, a single request starts a run of units back to back until the count is used up. When the last unit is written, the channel raises a sticky end flag and stops. It raises an interrupt if that is enabled. Software clears the flag to run the channel again.

Top module: `dmach_top`

## Requirements
- R1: After reset all four registers read zero, `mem_req` is low and `irq` is low.
- R2: Register offsets are 0 = source pointer, 1 = destination pointer, 2 = count, 3 = control. A write stores the value and a read returns it. The count keeps bits 23:0 only and reads back zero above them.
- R3: Each unit reads at the source pointer with `mem_we` low, then writes the data it read at the destination pointer with `mem_we` high. `mem_size` shows the unit-size field. A request and its address hold until `mem_ack`.
- R4: The control word has these fields: bit 0 enable, bit 1 interrupt enable, bit 2 end flag, bit 3 burst, bits 5:4 size, bits 7:6 source mode, bits 9:8 destination mode. Size codes 00/01/10/11 mean 1/2/4/16 bytes. Mode 01 adds the unit size after each unit, mode 10 subtracts it, and modes 00 and 11 leave the pointer unchanged.
- R5: Each finished unit lowers the count by one. When the count reaches zero, the end flag (control bit 2) is set and no further memory request is issued.
- R6: A count of zero stands for 16,777,216 units. One unit from a zero count leaves 0xFFFFFF and does not set the end flag.
- R7: With bit 3 clear (cycle-steal), `dreq` is sampled only while the channel is idle. Each sample moves one unit, after which `mem_req` drops.
- R8: With bit 3 set (burst), one sampled `dreq` starts units that follow each other without further `dreq` until the count reaches zero.
- R9: `irq` is high exactly while the end flag and the interrupt enable are both set.
- R10: No unit starts while enable is 0 or the end flag is 1. Writing 0 to bit 2 clears the flag and lets the channel run again. Writing 1 to bit 2 does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| dreq | input | 1 | Transfer request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_size | output | 2 | Unit-size code of the access |
| mem_wdata | output | DATA_W | Write data, low bytes used |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes in this cycle |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The copy path is tested under several setups. Increment on both sides with 4-byte burst units shows whether the two pointers are ordered and stepped correctly. A 16-byte unit with a falling source and a fixed destination shows whether subtraction is used and whether the size scales the step. A reserved source mode with an incrementing byte destination shows whether code 11 is treated as fixed. Cycle-steal pulses are counted unit by unit against the count register, which separates the two pacing modes. The zero-count run and the blocked-request runs (channel disabled, end flag set, write of 1 to the flag) separate a correct wrap and a correct gate from an early stop or a stray start.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [1:0] {
        PM_FIXED = 2'b00,
        PM_UP    = 2'b01,
        PM_DOWN  = 2'b10,
        PM_RSVD  = 2'b11
    } ptr_mode_e;

    typedef enum logic [1:0] {
        SZ_1  = 2'b00,
        SZ_2  = 2'b01,
        SZ_4  = 2'b10,
        SZ_16 = 2'b11
    } unit_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } seq_state_e;

    // Control word, bit 0 at the bottom of the struct
    typedef struct packed {
        ptr_mode_e  dst_mode;  // 9:8
        ptr_mode_e  src_mode;  // 7:6
        unit_size_e size;      // 5:4
        logic       burst;     // 3
        logic       done;      // 2
        logic       irq_en;    // 1
        logic       enable;    // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] OFS_SRC  = 2'd0;
    localparam logic [1:0] OFS_DST  = 2'd1;
    localparam logic [1:0] OFS_CNT  = 2'd2;
    localparam logic [1:0] OFS_CTRL = 2'd3;

    function automatic logic [4:0] unit_bytes(unit_size_e s);
        case (s)
            SZ_1:    return 5'd1;
            SZ_2:    return 5'd2;
            SZ_4:    return 5'd4;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/dmach_addr_step.sv
module dmach_addr_step
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  ptr_mode_e         mode_i,
    input  unit_size_e        size_i,
    output logic [ADDR_W-1:0] next_o
);

    logic [ADDR_W-1:0] step;

    always_comb begin
        step = ADDR_W'(unit_bytes(size_i));
        case (mode_i)
            PM_UP:   next_o = addr_i + step;
            PM_DOWN: next_o = addr_i - step;
            default: next_o = addr_i;   // fixed and reserved code
        endcase
    end

endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
    import dmach_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic burst_i,
    input  logic dreq_i,
    input  logic last_i,
    input  logic mem_ack_i,
    output logic mem_req_o,
    output logic mem_we_o,
    output logic capture_o,
    output logic unit_done_o
);

    seq_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (run_i && dreq_i) state_d = ST_READ;
            end
            ST_READ: begin
                if (mem_ack_i) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ack_i) begin
                    if (burst_i && run_i && !last_i) state_d = ST_READ;
                    else                             state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign mem_req_o   = (state_q != ST_IDLE);
    assign mem_we_o    = (state_q == ST_WRITE);
    assign capture_o   = (state_q == ST_READ)  && mem_ack_i;
    assign unit_done_o = (state_q == ST_WRITE) && mem_ack_i;

    // R3: a finished read is followed by the write of the same unit
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |=> (mem_req_o && mem_we_o));

    // R7: cycle-steal frees the port after each unit
    a_r7_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done_o && !burst_i) |=> !mem_req_o);

    // R8: burst chains into the next read without a new request
    a_r8_burst_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done_o && burst_i && run_i && !last_i) |=> (mem_req_o && !mem_we_o));

    // R10: an idle channel that may not run stays idle
    a_r10_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_o && !run_i) |=> !mem_req_o);

endmodule

// File: rtl/dmach_top.sv
module dmach_top
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 128,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dreq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              irq
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        ctrl_t             ctrl;
        logic [DATA_W-1:0] data_buf;
    } chan_t;

    chan_t r_d, r_q;

    logic              run, last, capture, unit_done;
    logic [ADDR_W-1:0] src_next, dst_next;
    ctrl_t             wr_ctrl;

    assign run  = r_q.ctrl.enable && !r_q.ctrl.done;
    assign last = (r_q.cnt == CNT_ONE);

    dmach_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
        .addr_i (r_q.src),
        .mode_i (r_q.ctrl.src_mode),
        .size_i (r_q.ctrl.size),
        .next_o (src_next)
    );

    dmach_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
        .addr_i (r_q.dst),
        .mode_i (r_q.ctrl.dst_mode),
        .size_i (r_q.ctrl.size),
        .next_o (dst_next)
    );

    dmach_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .burst_i     (r_q.ctrl.burst),
        .dreq_i      (dreq),
        .last_i      (last),
        .mem_ack_i   (mem_ack),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .capture_o   (capture),
        .unit_done_o (unit_done)
    );

    always_comb begin
        r_d     = r_q;
        wr_ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        if (reg_we) begin
            case (reg_addr)
                OFS_SRC: r_d.src = reg_wdata[ADDR_W-1:0];
                OFS_DST: r_d.dst = reg_wdata[ADDR_W-1:0];
                OFS_CNT: r_d.cnt = reg_wdata[CNT_W-1:0];
                default: begin
                    r_d.ctrl      = wr_ctrl;
                    // end flag can only be cleared by software
                    r_d.ctrl.done = r_q.ctrl.done && wr_ctrl.done;
                end
            endcase
        end
        if (capture) r_d.data_buf = mem_rdata;
        // hardware progress wins over a same-cycle register write
        if (unit_done) begin
            r_d.src = src_next;
            r_d.dst = dst_next;
            r_d.cnt = r_q.cnt - CNT_ONE;
            if (last) r_d.ctrl.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_addr  = mem_we ? r_q.dst : r_q.src;
    assign mem_size  = r_q.ctrl.size;
    assign mem_wdata = r_q.data_buf;
    assign irq       = r_q.ctrl.done && r_q.ctrl.irq_en;

    always_comb begin
        case (reg_addr)
            OFS_SRC: reg_rdata = 32'(r_q.src);
            OFS_DST: reg_rdata = 32'(r_q.dst);
            OFS_CNT: reg_rdata = 32'(r_q.cnt);
            default: reg_rdata = 32'(r_q.ctrl);
        endcase
    end

    // R5: a set end flag keeps the memory port quiet
    a_r5_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ctrl.done |-> !mem_req);

    // R5: every finished unit takes exactly one off the count
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        unit_done |=> (r_q.cnt == $past(r_q.cnt) - CNT_ONE));

    // R4: a fixed or reserved source mode leaves the source pointer alone
    a_r4_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_done && (r_q.ctrl.src_mode == PM_FIXED || r_q.ctrl.src_mode == PM_RSVD))
        |=> $stable(r_q.src));

    // R3: an unanswered request keeps its address
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !reg_we) |=> (mem_req && $stable(mem_addr)));

    // R9: the interrupt only comes up after a unit end or a control write
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(unit_done) || $past(reg_we)));

endmodule

// File: tb/tb_dmach_top.sv
module tb_dmach_top;
    import dmach_pkg::*;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 128;
    localparam int MEM_B  = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              dreq = 1'b0;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [1:0]        mem_size;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              mem_ack = 1'b0;
    logic              irq;

    logic [7:0] mem [MEM_B];
    int n_wr = 0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] last_wr_addr = '0;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    dmach_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(24)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .irq(irq)
    );

    function automatic int nbytes(logic [1:0] s);
        case (s)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 16;
        endcase
    endfunction

    // memory model: answers one access every other cycle
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (mem_we) begin
                for (int i = 0; i < nbytes(mem_size); i++)
                    mem[(mem_addr + 32'(i)) % MEM_B] = mem_wdata[8*i +: 8];
                n_wr = n_wr + 1;
                last_wr_addr = mem_addr;
            end else begin
                logic [DATA_W-1:0] rd;
                rd = '0;
                for (int i = 0; i < nbytes(mem_size); i++)
                    rd[8*i +: 8] = mem[(mem_addr + 32'(i)) % MEM_B];
                mem_rdata = rd;
                last_rd_addr = mem_addr;
            end
            mem_ack = 1'b1;
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] mkctrl(logic [1:0] dm, logic [1:0] sm, logic [1:0] sz,
                                           logic bst, logic ie, logic en);
        return {22'd0, dm, sm, sz, bst, 1'b0, ie, en};
    endfunction

    task automatic pulse_dreq();
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_done();
        logic [31:0] c;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rd(OFS_CTRL, c);
            if (c[2]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register reset", v, 32'h0);
        end
        chk("R1 mem_req reset", 32'(mem_req), 32'h0);
        chk("R1 irq reset", 32'(irq), 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(OFS_SRC, 32'hDEAD_BEE0); rd(OFS_SRC, v); chk("R2 src readback", v, 32'hDEAD_BEE0);
        wr(OFS_DST, 32'h1234_5678); rd(OFS_DST, v); chk("R2 dst readback", v, 32'h1234_5678);
        wr(OFS_CNT, 32'hAB12_3456); rd(OFS_CNT, v); chk("R2 count 24 bits", v, 32'h0012_3456);
        wr(OFS_CTRL, mkctrl(2'b10, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0));
        rd(OFS_CTRL, v); chk("R2 ctrl readback", v, mkctrl(2'b10, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0));
        wr(OFS_CTRL, 32'h0); wr(OFS_SRC, 0); wr(OFS_DST, 0); wr(OFS_CNT, 0);
    endtask

    task automatic t_burst_inc();
        logic [31:0] v;
        int w0, mism;
        for (int i = 0; i < 64; i++) mem[32'h100 + i] = 8'(i) ^ 8'h5A;
        for (int i = 0; i < 16; i++) mem[32'h200 + i] = 8'h00;
        w0 = n_wr;
        wr(OFS_SRC, 32'h100); wr(OFS_DST, 32'h200); wr(OFS_CNT, 3);
        wr(OFS_CTRL, mkctrl(2'b01, 2'b01, 2'b10, 1'b1, 1'b1, 1'b1));
        pulse_dreq();
        wait_done();
        mism = 0;
        for (int i = 0; i < 12; i++) if (mem[32'h200 + i] !== mem[32'h100 + i]) mism++;
        chk("R3 copied bytes mismatches", 32'(mism), 0);
        chk("R3 untouched byte after copy", 32'(mem[32'h20C]), 0);
        chk("R3 last read address", last_rd_addr, 32'h108);
        chk("R3 last write address", last_wr_addr, 32'h208);
        chk("R8 units in one burst", 32'(n_wr - w0), 3);
        rd(OFS_SRC, v); chk("R4 src up by 4", v, 32'h10C);
        rd(OFS_DST, v); chk("R4 dst up by 4", v, 32'h20C);
        rd(OFS_CNT, v); chk("R5 count at end", v, 0);
        rd(OFS_CTRL, v); chk("R5 end flag set", v[2], 1'b1);
        chk("R9 irq with enable", 32'(irq), 1);
        idle(6);
        chk("R5 no more units", 32'(n_wr - w0), 3);
        wr(OFS_CTRL, 32'h0);
        chk("R9 irq cleared with flag", 32'(irq), 0);
    endtask

    task automatic t_modes();
        logic [31:0] v;
        int mism;
        for (int i = 0; i < 16; i++) begin
            mem[32'h3F0 + i] = 8'hC0 + 8'(i);
            mem[32'h400 + i] = 8'h10 + 8'(i);
            mem[32'h300 + i] = 8'h00;
        end
        wr(OFS_SRC, 32'h400); wr(OFS_DST, 32'h300); wr(OFS_CNT, 2);
        wr(OFS_CTRL, mkctrl(2'b00, 2'b10, 2'b11, 1'b1, 1'b0, 1'b1));
        pulse_dreq();
        wait_done();
        rd(OFS_SRC, v); chk("R4 src down by 16 twice", v, 32'h3E0);
        rd(OFS_DST, v); chk("R4 dst fixed", v, 32'h300);
        chk("R4 second read address", last_rd_addr, 32'h3F0);
        mism = 0;
        for (int i = 0; i < 16; i++) if (mem[32'h300 + i] !== 8'hC0 + 8'(i)) mism++;
        chk("R3 16-byte unit content", 32'(mism), 0);
        chk("R9 no irq without enable", 32'(irq), 0);
        mem[32'h500] = 8'h77; mem[32'h501] = 8'h11;
        mem[32'h600] = 8'h00; mem[32'h601] = 8'h00;
        wr(OFS_CTRL, 32'h0);
        wr(OFS_SRC, 32'h500); wr(OFS_DST, 32'h600); wr(OFS_CNT, 2);
        wr(OFS_CTRL, mkctrl(2'b01, 2'b11, 2'b00, 1'b1, 1'b0, 1'b1));
        pulse_dreq();
        wait_done();
        rd(OFS_SRC, v); chk("R4 reserved mode stays fixed", v, 32'h500);
        rd(OFS_DST, v); chk("R4 dst up by 1", v, 32'h602);
        chk("R4 byte copy 0", 32'(mem[32'h600]), 32'h77);
        chk("R4 byte copy 1", 32'(mem[32'h601]), 32'h77);
        wr(OFS_CTRL, 32'h0);
    endtask

    task automatic t_steal();
        logic [31:0] v;
        int w0;
        w0 = n_wr;
        wr(OFS_SRC, 32'h700); wr(OFS_DST, 32'h800); wr(OFS_CNT, 3);
        wr(OFS_CTRL, mkctrl(2'b01, 2'b01, 2'b01, 1'b0, 1'b0, 1'b1));
        pulse_dreq(); idle(12);
        rd(OFS_CNT, v); chk("R7 one unit per request", v, 2);
        chk("R7 write count", 32'(n_wr - w0), 1);
        chk("R7 port released", 32'(mem_req), 0);
        rd(OFS_SRC, v); chk("R4 src up by 2", v, 32'h702);
        pulse_dreq(); idle(12);
        rd(OFS_CNT, v); chk("R7 second request", v, 1);
        rd(OFS_CTRL, v); chk("R5 flag clear before last", v[2], 1'b0);
        pulse_dreq(); idle(12);
        rd(OFS_CTRL, v); chk("R5 flag set on last", v[2], 1'b1);
        pulse_dreq(); idle(12);
        chk("R10 no unit while flag set", 32'(n_wr - w0), 3);
        rd(OFS_CNT, v); chk("R10 count kept", v, 0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        wr(OFS_CTRL, 32'h0);
        wr(OFS_SRC, 32'h900); wr(OFS_DST, 32'hA00); wr(OFS_CNT, 0);
        wr(OFS_CTRL, mkctrl(2'b01, 2'b01, 2'b00, 1'b0, 1'b1, 1'b1));
        pulse_dreq(); idle(12);
        rd(OFS_CNT, v); chk("R6 zero count wraps", v, 32'hFF_FFFF);
        rd(OFS_CTRL, v); chk("R6 no end flag", v[2], 1'b0);
        pulse_dreq(); idle(12);
        rd(OFS_CNT, v); chk("R6 next unit", v, 32'hFF_FFFE);
        wr(OFS_CTRL, 32'h0);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        int w0;
        w0 = n_wr;
        wr(OFS_CNT, 5);
        @(negedge clk); dreq = 1'b1;
        idle(20);
        dreq = 1'b0;
        chk("R10 disabled channel idle", 32'(n_wr - w0), 0);
        wr(OFS_CTRL, 32'h4);
        rd(OFS_CTRL, v); chk("R10 writing 1 does not set flag", v[2], 1'b0);
        wr(OFS_SRC, 32'hB00); wr(OFS_DST, 32'hC00); wr(OFS_CNT, 1);
        wr(OFS_CTRL, mkctrl(2'b01, 2'b01, 2'b00, 1'b0, 1'b0, 1'b1));
        pulse_dreq(); idle(12);
        rd(OFS_CTRL, v); chk("R10 single unit ends", v[2], 1'b1);
        wr(OFS_CNT, 1);
        pulse_dreq(); idle(12);
        chk("R10 blocked by flag", 32'(n_wr - w0), 1);
        wr(OFS_CTRL, mkctrl(2'b01, 2'b01, 2'b00, 1'b0, 1'b0, 1'b1));
        rd(OFS_CTRL, v); chk("R10 flag cleared", v[2], 1'b0);
        pulse_dreq(); idle(12);
        chk("R10 restart moves a unit", 32'(n_wr - w0), 2);
        rd(OFS_CTRL, v); chk("R10 ends again", v[2], 1'b1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_regs();
        t_burst_inc();
        t_modes();
        t_steal();
        t_zero();
        t_gate();
        summary();
    end

endmodule